// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns one-word access requests from a local controller into the strobe pattern that a raw NAND flash device expects on its asynchronous bus. Each access is a command-latch, address-latch, data-write or data-read cycle. It runs through four timed phases, all counted in controller clock cycles. In setup, chip enable and the latch lines settle. In wait, the write or read strobe is held low. In hold, the strobe is back high while the address and control lines stay put. A fourth count delays the moment the data bus driver turns on.

Two timing words are kept. The attribute word paces command and address cycles, and the common word paces data transfers. A data read that directly follows a command or address cycle is preceded by an extra latch-to-read gap, and each of the two cases has its own programmable count. An optional ready/busy input can stretch the strobe-low phase. A master enable gates everything. The bus can run 8 or 16 bits wide for data cycles.

Configuration is written through a small word port. Requests are single-cycle pulses that are taken only while the block is idle and enabled.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset both timing words read as 0x0A0A0A0A, the control word holds enable off, ready-wait off, 8-bit width and both latch-to-read counts at 0xF, and the outputs are idle: busy low, chip enable high, both strobes high, latches low, data driver off, no read result.
- R2: While the enable bit is clear, a request is not taken: busy stays low and chip enable stays high.
- R3: Each timing word packs setup in bits 7:0, wait in bits 15:8, hold in bits 23:16 and driver-delay in bits 31:24. An accepted access keeps busy and chip enable asserted for setup+wait+hold cycles, plus any read gap. Its strobe is low for exactly the wait count, and it is not low during the setup cycles.
- R4: A setup, wait or hold field programmed as 0 behaves as 1.
- R5: Command (kind 0) and address (kind 1) accesses take their counts from the attribute word. Data write (kind 2) and data read (kind 3) take them from the common word.
- R6: A command access holds the command latch high, and an address access holds the address latch high, for the whole access and never both together. Kinds 0, 1 and 2 pulse the write strobe, and kind 3 pulses the read strobe.
- R7: A read that directly follows a command access is preceded by (command-to-read count + 1) cycles with chip enable low and all strobes and latches inactive. After an address access the address-to-read count is used instead. After a data access, or as the first access after reset, no gap is inserted.
- R8: On kinds 0 to 2 the data driver turns on once driver-delay cycles have elapsed from the first setup cycle. It stays on until the last hold cycle, giving max(0, setup+wait+hold − delay) driven cycles. It is never on during a read.
- R9: With ready-wait enabled, the wait phase continues past its count for as long as the ready input is low. With ready-wait disabled, the ready input has no effect on the cycle length.
- R10: A read produces a one-cycle result pulse carrying the bus value sampled on the edge that ends the wait phase. In 8-bit mode only the low byte is kept and the upper byte is zero.
- R11: In 16-bit mode a data write drives the full request word. In 8-bit mode, and on every command or address access, only the low byte is driven and the upper byte is zero. The driven value is stable while the driver is on.
- R12: Config address 0 loads the common word and address 1 loads the attribute word. Address 2 loads control: bit 0 enable, bit 1 ready-wait, bits 5:4 width (1 selects 16-bit, any other value 8-bit), bits 11:8 command-to-read count, bits 15:12 address-to-read count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration word select |
| cfgWdata | input | 32 | Configuration write data |
| reqValid | input | 1 | Access request, taken when idle and enabled |
| reqKind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| reqData | input | 16 | Byte or word to place on the bus |
| busy | output | 1 | High from acceptance to the end of hold |
| nandRdy | input | 1 | Device ready (high) / busy (low) |
| nandDqIn | input | 16 | Data bus input from the device |
| rdValid | output | 1 | One-cycle read result pulse |
| rdData | output | 16 | Captured read data |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDqOut | output | 16 | Data bus output value |
| nandDqOe | output | 1 | Data bus driver enable |

## Verification
The embedded properties assume that configuration writes and requests come from a synchronous master and change only between clock edges. They also assume that the ready input is a clean synchronous level. The latch and strobe exclusivity checks rely on the request kind being one of the four defined codes. The stimulus meets these assumptions: it drives every input at the falling edge, issues a request only after busy has dropped, and rewrites configuration only between accesses. It moves the ready input only within a single data-write access whose length it predicts.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_READ  = 2'd3
  } accKind_t;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DELAY = 3'd1,
    PH_SETUP = 3'd2,
    PH_WAIT  = 3'd3,
    PH_HOLD  = 3'd4
  } phase_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadReq;
    logic loadWide;
    logic capture;
    logic captureWide;
    logic driveOe;
  } dpCtl_t;

  parameter logic [1:0] CFG_COMMON = 2'd0;
  parameter logic [1:0] CFG_ATTR   = 2'd1;
  parameter logic [1:0] CFG_CTRL   = 2'd2;

endpackage

// File: rtl/nand_seq_cfg.sv
module nand_seq_cfg
  import nand_seq_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int DLY_W   = 4,
  localparam int WORD_W = 4 * FIELD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [WORD_W-1:0] cfgWdata,
  output logic [WORD_W-1:0] commonTim,
  output logic [WORD_W-1:0] attrTim,
  output logic              enable,
  output logic              waitEn,
  output logic              wide,
  output logic [DLY_W-1:0]  clrDly,
  output logic [DLY_W-1:0]  alrDly
);

  localparam logic [WORD_W-1:0] TIM_RST = {4{FIELD_W'(10)}};
  localparam int CLR_LSB = 8;
  localparam int ALR_LSB = CLR_LSB + DLY_W;

  logic [1:0] widthSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commonTim <= TIM_RST;
      attrTim   <= TIM_RST;
      enable    <= 1'b0;
      waitEn    <= 1'b0;
      widthSel  <= 2'd0;
      clrDly    <= '1;
      alrDly    <= '1;
    end else if (cfgWe) begin
      case (cfgAddr)
        CFG_COMMON: commonTim <= cfgWdata;
        CFG_ATTR:   attrTim   <= cfgWdata;
        CFG_CTRL: begin
          enable   <= cfgWdata[0];
          waitEn   <= cfgWdata[1];
          widthSel <= cfgWdata[5:4];
          clrDly   <= cfgWdata[CLR_LSB +: DLY_W];
          alrDly   <= cfgWdata[ALR_LSB +: DLY_W];
        end
        default: ;
      endcase
    end
  end

  assign wide = (widthSel == 2'd1);

  assert_cfg_load_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgAddr == CFG_ATTR) |=> (attrTim == $past(cfgWdata)));

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int DLY_W   = 4,
  localparam int WORD_W = 4 * FIELD_W,
  localparam int ELAP_W = FIELD_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [WORD_W-1:0] commonTim,
  input  logic [WORD_W-1:0] attrTim,
  input  logic              enable,
  input  logic              waitEn,
  input  logic              wide,
  input  logic [DLY_W-1:0]  clrDly,
  input  logic [DLY_W-1:0]  alrDly,
  input  logic              nandRdy,
  output logic              busy,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output dpCtl_t            dpCtl
);

  localparam int SET_LSB  = 0;
  localparam int WAIT_LSB = FIELD_W;
  localparam int HOLD_LSB = 2 * FIELD_W;
  localparam int HIZ_LSB  = 3 * FIELD_W;

  phase_t              phase;
  accKind_t            kindQ, lastKind, reqKindT;
  logic [WORD_W-1:0]   timQ, selTim;
  logic [FIELD_W-1:0]  cnt;
  logic [ELAP_W-1:0]   elapsed;
  logic                wideQ, accept, inCycle, waitDone, cntZero;

  function automatic logic [FIELD_W-1:0] lenLess1(input logic [FIELD_W-1:0] f);
    return (f == '0) ? '0 : f - 1'b1;
  endfunction

  assign reqKindT = accKind_t'(reqKind);
  assign accept   = reqValid && enable && (phase == PH_IDLE);
  assign selTim   = (reqKindT == KIND_CMD || reqKindT == KIND_ADDR) ? attrTim : commonTim;
  assign cntZero  = (cnt == '0);
  assign waitDone = cntZero && (!waitEn || nandRdy);
  assign inCycle  = (phase == PH_SETUP) || (phase == PH_WAIT) || (phase == PH_HOLD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      kindQ    <= KIND_CMD;
      lastKind <= KIND_WRITE;
      timQ     <= '0;
      elapsed  <= '0;
      wideQ    <= 1'b0;
    end else begin
      if (inCycle && elapsed != '1) elapsed <= elapsed + 1'b1;
      case (phase)
        PH_IDLE: if (accept) begin
          kindQ    <= reqKindT;
          lastKind <= reqKindT;
          timQ     <= selTim;
          wideQ    <= wide;
          elapsed  <= '0;
          if (reqKindT == KIND_READ && lastKind == KIND_CMD) begin
            phase <= PH_DELAY;
            cnt   <= FIELD_W'(clrDly);
          end else if (reqKindT == KIND_READ && lastKind == KIND_ADDR) begin
            phase <= PH_DELAY;
            cnt   <= FIELD_W'(alrDly);
          end else begin
            phase <= PH_SETUP;
            cnt   <= lenLess1(selTim[SET_LSB +: FIELD_W]);
          end
        end
        PH_DELAY: begin
          if (cntZero) begin
            phase   <= PH_SETUP;
            cnt     <= lenLess1(timQ[SET_LSB +: FIELD_W]);
            elapsed <= '0;
          end else cnt <= cnt - 1'b1;
        end
        PH_SETUP: begin
          if (cntZero) begin
            phase <= PH_WAIT;
            cnt   <= lenLess1(timQ[WAIT_LSB +: FIELD_W]);
          end else cnt <= cnt - 1'b1;
        end
        PH_WAIT: begin
          if (!cntZero) cnt <= cnt - 1'b1;
          else if (waitDone) begin
            phase <= PH_HOLD;
            cnt   <= lenLess1(timQ[HOLD_LSB +: FIELD_W]);
          end
        end
        PH_HOLD: begin
          if (cntZero) phase <= PH_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy    = (phase != PH_IDLE);
  assign nandCeN = !busy;
  assign nandCle = inCycle && (kindQ == KIND_CMD);
  assign nandAle = inCycle && (kindQ == KIND_ADDR);
  assign nandWeN = !((phase == PH_WAIT) && (kindQ != KIND_READ));
  assign nandReN = !((phase == PH_WAIT) && (kindQ == KIND_READ));

  always_comb begin
    dpCtl             = '0;
    dpCtl.loadReq     = accept;
    dpCtl.loadWide    = wide && (reqKindT == KIND_WRITE);
    dpCtl.capture     = (phase == PH_WAIT) && (kindQ == KIND_READ) && waitDone;
    dpCtl.captureWide = wideQ;
    dpCtl.driveOe     = inCycle && (kindQ != KIND_READ) &&
                        (elapsed >= ELAP_W'(timQ[HIZ_LSB +: FIELD_W]));
  end

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));
  assert_latch_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));
  assert_strobe_in_ce_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN || !nandReN) |-> !nandCeN);
  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !enable) |=> !busy);
  assert_oe_not_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.driveOe |-> nandReN);

endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] nandDqIn,
  output logic [DATA_W-1:0] nandDqOut,
  output logic              nandDqOe,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ   <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= dpCtl.capture;
      if (dpCtl.loadReq)
        dataQ <= dpCtl.loadWide ? reqData : DATA_W'(reqData[LANE_W-1:0]);
      if (dpCtl.capture)
        rdData <= dpCtl.captureWide ? nandDqIn : DATA_W'(nandDqIn[LANE_W-1:0]);
    end
  end

  assign nandDqOut = dataQ;
  assign nandDqOe  = dpCtl.driveOe;

  assert_dq_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (nandDqOe && $past(nandDqOe)) |-> $stable(nandDqOut));
  assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 8,
  parameter int DLY_W   = 4,
  localparam int WORD_W = 4 * FIELD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [WORD_W-1:0] cfgWdata,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [DATA_W-1:0] reqData,
  output logic              busy,
  input  logic              nandRdy,
  input  logic [DATA_W-1:0] nandDqIn,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [DATA_W-1:0] nandDqOut,
  output logic              nandDqOe
);

  logic [WORD_W-1:0] commonTim, attrTim;
  logic              enable, waitEn, wide;
  logic [DLY_W-1:0]  clrDly, alrDly;
  dpCtl_t            dpCtl;

  nand_seq_cfg #(.FIELD_W(FIELD_W), .DLY_W(DLY_W)) uCfg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .commonTim(commonTim), .attrTim(attrTim), .enable(enable), .waitEn(waitEn),
    .wide(wide), .clrDly(clrDly), .alrDly(alrDly)
  );

  nand_seq_ctrl #(.FIELD_W(FIELD_W), .DLY_W(DLY_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .commonTim(commonTim), .attrTim(attrTim), .enable(enable), .waitEn(waitEn),
    .wide(wide), .clrDly(clrDly), .alrDly(alrDly), .nandRdy(nandRdy),
    .busy(busy), .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .dpCtl(dpCtl)
  );

  nand_seq_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .reqData(reqData), .nandDqIn(nandDqIn),
    .nandDqOut(nandDqOut), .nandDqOe(nandDqOe), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: tb/tb_nand_strobe_seq.sv
`timescale 1ns/1ps
module tb_nand_strobe_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = 2'd0;
  logic [31:0] cfgWdata = 32'd0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [15:0] reqData = 16'd0;
  logic        nandRdy = 1'b1;
  logic [15:0] nandDqIn = 16'd0;
  logic        busy, rdValid, nandCeN, nandCle, nandAle, nandWeN, nandReN, nandDqOe;
  logic [15:0] rdData, nandDqOut;

  always #4 clk = ~clk;

  nand_strobe_seq dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .reqValid(reqValid), .reqKind(reqKind), .reqData(reqData), .busy(busy),
    .nandRdy(nandRdy), .nandDqIn(nandDqIn), .rdValid(rdValid), .rdData(rdData),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandDqOut(nandDqOut), .nandDqOe(nandDqOe)
  );

  typedef struct {
    int busyCyc; int preCyc; int weCyc; int reCyc; int cleCyc; int aleCyc;
    int oeCyc; logic [15:0] dqVal; int rdCnt; logic [15:0] rdVal; string tag;
  } expTxn_t;

  expTxn_t expQ[$];
  int testsRun = 0, testsFail = 0;

  // bench model of the configuration
  logic [31:0] mCommon = 32'h0A0A0A0A, mAttr = 32'h0A0A0A0A;
  int mClr = 15, mAlr = 15, mLast = 2;
  bit mWide = 0, mWaitEn = 0;

  function automatic int lenOf(input logic [7:0] f);
    return (f == 8'd0) ? 1 : int'(f);
  endfunction

  task automatic cfgWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (a == 2'd0) mCommon = d;
    else if (a == 2'd1) mAttr = d;
    else if (a == 2'd2) begin
      mWaitEn = d[1]; mWide = (d[5:4] == 2'd1);
      mClr = int'(d[11:8]); mAlr = int'(d[15:12]);
    end
  endtask

  // driver: predicts the access, queues it, then drives it
  task automatic access(input logic [1:0] kind, input logic [15:0] data,
                        input logic [15:0] dqIn, input int rdyRel, input string tag);
    expTxn_t e;
    logic [31:0] tim;
    int s, w, h, hiz, d, total;
    tim = (kind < 2) ? mAttr : mCommon;
    s = lenOf(tim[7:0]); w = lenOf(tim[15:8]); h = lenOf(tim[23:16]); hiz = int'(tim[31:24]);
    d = 0;
    if (kind == 2'd3 && mLast == 0) d = mClr + 1;
    if (kind == 2'd3 && mLast == 1) d = mAlr + 1;
    if (rdyRel >= 0 && mWaitEn && (rdyRel - s + 1) > w) w = rdyRel - s + 1;
    total = s + w + h;
    e.busyCyc = d + total;
    e.preCyc  = d + s;
    e.weCyc   = (kind != 2'd3) ? w : 0;
    e.reCyc   = (kind == 2'd3) ? w : 0;
    e.cleCyc  = (kind == 2'd0) ? total : 0;
    e.aleCyc  = (kind == 2'd1) ? total : 0;
    e.oeCyc   = (kind != 2'd3 && total > hiz) ? total - hiz : 0;
    e.dqVal   = (e.oeCyc == 0) ? 16'h0 : ((kind == 2'd2 && mWide) ? data : {8'h00, data[7:0]});
    e.rdCnt   = (kind == 2'd3) ? 1 : 0;
    e.rdVal   = (kind == 2'd3) ? (mWide ? dqIn : {8'h00, dqIn[7:0]}) : 16'h0;
    e.tag     = tag;
    expQ.push_back(e);
    mLast = int'(kind);
    @(negedge clk);
    while (busy) @(negedge clk);
    nandDqIn = dqIn;
    if (rdyRel >= 0) nandRdy = 1'b0;
    reqValid = 1'b1; reqKind = kind; reqData = data;
    @(negedge clk);
    reqValid = 1'b0;
    if (rdyRel >= 0) begin
      repeat (rdyRel) @(negedge clk);
      nandRdy = 1'b1;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkIgnored(input string tag);
    int bad = 0;
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'd0; reqData = 16'h0055;
    repeat (6) begin
      @(negedge clk);
      if (busy || !nandCeN || nandDqOe) bad++;
    end
    reqValid = 1'b0;
    testsRun++;
    if (bad != 0) begin
      testsFail++;
      $display("FAIL %s: request taken while disabled, active cycles %0d expected 0", tag, bad);
    end
  endtask

  // monitor: gathers each access as it happens and compares at its end
  int aBusy, aPre, aWe, aRe, aCle, aAle, aOe, aRd, aCeBad;
  logic [15:0] aDq, aRdVal;
  bit prevBusy = 0, seenStrobe, dqBad;
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) begin
        if (!prevBusy) begin
          aBusy = 0; aPre = 0; aWe = 0; aRe = 0; aCle = 0; aAle = 0; aOe = 0;
          aRd = 0; aCeBad = 0; aDq = 16'h0; aRdVal = 16'h0; seenStrobe = 0; dqBad = 0;
        end
        aBusy++;
        if (nandCeN) aCeBad++;
        if (!nandWeN || !nandReN) seenStrobe = 1;
        if (!seenStrobe) aPre++;
        if (!nandWeN) aWe++;
        if (!nandReN) aRe++;
        if (nandCle) aCle++;
        if (nandAle) aAle++;
        if (nandDqOe) begin
          if (aOe == 0) aDq = nandDqOut;
          else if (nandDqOut != aDq) dqBad = 1;
          aOe++;
        end
        if (rdValid) begin aRd++; aRdVal = rdData; end
      end else if (prevBusy) begin
        expTxn_t e;
        testsRun++;
        if (expQ.size() == 0) begin
          testsFail++;
          $display("FAIL R3: unexpected access, busy %0d expected none", aBusy);
        end else begin
          e = expQ.pop_front();
          if (rdValid) begin aRd++; aRdVal = rdData; end
          if (aBusy != e.busyCyc || aPre != e.preCyc || aWe != e.weCyc || aRe != e.reCyc ||
              aCle != e.cleCyc || aAle != e.aleCyc || aOe != e.oeCyc || aDq != e.dqVal ||
              dqBad || aCeBad != 0 || aRd != e.rdCnt || aRdVal != e.rdVal) begin
            testsFail++;
            $display("FAIL %s: actual busy=%0d pre=%0d we=%0d re=%0d cle=%0d ale=%0d oe=%0d dq=%h rd=%0d/%h ceBad=%0d dqBad=%0d expected busy=%0d pre=%0d we=%0d re=%0d cle=%0d ale=%0d oe=%0d dq=%h rd=%0d/%h",
                     e.tag, aBusy, aPre, aWe, aRe, aCle, aAle, aOe, aDq, aRd, aRdVal, aCeBad, dqBad,
                     e.busyCyc, e.preCyc, e.weCyc, e.reCyc, e.cleCyc, e.aleCyc, e.oeCyc, e.dqVal,
                     e.rdCnt, e.rdVal);
          end
        end
      end
      prevBusy = busy;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsFail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    testsRun++;
    if (busy || !nandCeN || !nandWeN || !nandReN || nandCle || nandAle || nandDqOe || rdValid) begin
      testsFail++;
      $display("FAIL R1: reset outputs busy=%b ce=%b we=%b re=%b cle=%b ale=%b oe=%b rv=%b expected 0 1 1 1 0 0 0 0",
               busy, nandCeN, nandWeN, nandReN, nandCle, nandAle, nandDqOe, rdValid);
    end
    checkIgnored("R2 disabled after reset");
    cfgWrite(2'd2, 32'h0000FF01);                       // R12 enable only
    access(2'd0, 16'h0070, 16'h0, -1, "R1 R3 R5 R6 R8 default command");
    access(2'd3, 16'h0, 16'h12A5, -1, "R7 R10 read after command");
    cfgWrite(2'd1, 32'h02010302);                       // R12 attribute word
    cfgWrite(2'd0, 32'h05020403);                       // R12 common word
    cfgWrite(2'd2, 32'h00006301);                       // R12 delays 3 and 6
    access(2'd1, 16'h001F, 16'h0, -1, "R5 R6 address");
    access(2'd3, 16'h0, 16'h3C5A, -1, "R7 read after address");
    access(2'd3, 16'h0, 16'h0F81, -1, "R7 read after read");
    access(2'd0, 16'h0090, 16'h0, -1, "R6 command");
    cfgWrite(2'd2, 32'h00006311);                       // R12 16-bit
    access(2'd2, 16'hBEEF, 16'h0, -1, "R11 wide write");
    access(2'd3, 16'h0, 16'hC3D2, -1, "R10 wide read");
    access(2'd0, 16'hAB90, 16'h0, -1, "R11 command low byte");
    cfgWrite(2'd0, 32'h00000000);
    access(2'd2, 16'h1234, 16'h0, -1, "R4 zero fields");
    cfgWrite(2'd1, 32'hFF010101);
    access(2'd1, 16'h0044, 16'h0, -1, "R8 delay beyond cycle");
    cfgWrite(2'd0, 32'h00010202);
    cfgWrite(2'd2, 32'h00006313);                       // R12 ready-wait on
    access(2'd2, 16'h5A5A, 16'h0, 9, "R9 busy extends wait");
    cfgWrite(2'd2, 32'h00006311);
    access(2'd2, 16'hA5A5, 16'h0, 9, "R9 ready ignored");
    cfgWrite(2'd2, 32'h00006310);
    checkIgnored("R2 disabled again");
    repeat (4) @(negedge clk);
    testsRun++;
    if (expQ.size() != 0) begin
      testsFail++;
      $display("FAIL R3: accesses never seen, actual %0d pending expected 0", expQ.size());
    end
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule